// File: doc/BRIEF.md
# Memory Address and Operand Assembly Unit

This block forms the memory address that a CPU core presents on every cycle. It also gathers multi-byte operands and addresses from consecutive byte reads. A two-bit source code picks the base address. The base can come from an internal address register, the program counter, the stack pointer, or a vector slot chosen by opcode bits. An index value from the register file's second read port can then be added, followed by an optional +1 for the second byte of a two-byte quantity.

Two registers collect read bytes under per-cycle control bits from the nanocode:

- **Operand register.** Builds a little-endian value of up to four bytes. It keeps a fill count so that each extend lands in the next free byte lane.
- **Operand-address register.** Builds a two-byte address. It can also take its low byte from the operand register. This lets an indirect pointer be fetched from the location that the address register itself points at, with the operand register holding the first byte in the meantime.

A PC-load control passes the address register to the new-PC output.

Top module: `addr_operand_unit`

## Requirements
- R1: Synchronous active-high reset clears the operand register, its fill count and the operand-address register to zero.
- R2: `src_sel` encodes the base address as 0 = operand-address register, 1 = `pc_in`, 2 = `sp_in`, 3 = vector. The vector address is 0xFFE0 + 2 × `vec_sel`.
- R3: When `addr_inc` is 1, 1 is added to the address, and the sum wraps modulo 65536.
- R4: When `idx_en` is 1, the low 16 bits of `idx_val` are added to the address, wrapping modulo 65536. When `idx_is_flags` is also 1, zero is added instead.
- R5: `opnd_load` sets the operand to the zero-extended `rd_data` and sets the fill count to one byte.
- R6: `opnd_ext` writes `rd_data` into byte lane number fill (lane 0 = bits 7:0) and increments the fill count. Once four bytes are held, an extend leaves the operand unchanged.
- R7: When `opnd_load` and `opnd_ext` are both 1, the load takes effect and the extend does not.
- R8: `oaddr_load` sets the operand-address register to the zero-extended `rd_data`.
- R9: `oaddr_ext` puts `rd_data` in bits 15:8 of the operand-address register and keeps bits 7:0.
- R10: `oaddr_ext_opnd` sets the operand-address register to {`rd_data`, operand bits 7:0}. Priority among the address-register controls is load, then extend, then extend-from-operand.
- R11: `pc_next` equals the operand-address register while `pc_load` is 1 and `pc_in` otherwise, in the same cycle.
- R12: With none of its load or extend controls active, each register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Base address source code |
| addr_inc | input | 1 | Add 1 to the address |
| idx_en | input | 1 | Add the index value to the address |
| idx_is_flags | input | 1 | Index port has selected the flags register; add zero instead |
| idx_val | input | 32 | Register-file index port value |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| vec_sel | input | 4 | Opcode bits choosing the vector slot |
| rd_data | input | 8 | Memory read byte |
| opnd_load | input | 1 | Load the operand register |
| opnd_ext | input | 1 | Extend the operand register |
| oaddr_load | input | 1 | Load the operand-address register |
| oaddr_ext | input | 1 | Extend the operand-address register with a high byte |
| oaddr_ext_opnd | input | 1 | Load the address register from read data and the operand low byte |
| pc_load | input | 1 | Pass the operand-address register to `pc_next` |
| mem_addr | output | 16 | Memory address for this cycle |
| operand | output | 32 | Assembled operand |
| pc_next | output | 16 | New program counter value |

## Verification
`mem_addr` and `pc_next` are combinational, so each is due in the same cycle as the controls that produce it. The bench drives those controls on a falling edge and samples these two outputs a quarter period later, before the next rising edge.

Register updates appear one rising edge after their control is applied. The bench checks them at the falling edge that follows that rising edge. The operand-address register is read back through `mem_addr` with source 0, or through `pc_next`.

// File: rtl/aou_pkg.sv
package aou_pkg;

    typedef enum logic [1:0] {
        SRC_OADDR  = 2'd0,
        SRC_PC     = 2'd1,
        SRC_SP     = 2'd2,
        SRC_VECTOR = 2'd3
    } addr_src_e;

    typedef struct packed {
        addr_src_e src;
        logic      inc;
        logic      idx_en;
        logic      idx_is_flags;
    } addr_ctrl_t;

    typedef struct packed {
        logic load;
        logic ext;
    } opnd_ctrl_t;

    typedef struct packed {
        logic load;
        logic ext;
        logic ext_opnd;
    } oaddr_ctrl_t;

    typedef enum logic [1:0] {
        OA_HOLD     = 2'd0,
        OA_LOAD     = 2'd1,
        OA_EXTEND   = 2'd2,
        OA_FROM_OPN = 2'd3
    } oaddr_act_e;

    function automatic oaddr_act_e oaddr_decide(oaddr_ctrl_t c);
        if (c.load)          return OA_LOAD;
        else if (c.ext)      return OA_EXTEND;
        else if (c.ext_opnd) return OA_FROM_OPN;
        else                 return OA_HOLD;
    endfunction

endpackage

// File: rtl/aou_addr_path.sv
module aou_addr_path
    import aou_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 32,
    parameter int VEC_W     = 4,
    parameter int VEC_SHIFT = 1,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
    input  addr_ctrl_t        ctrl,
    input  logic [ADDR_W-1:0] oaddr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    input  logic [VEC_W-1:0]  vec,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] idx_narrow;
    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] inc_term;

    assign vec_addr = VEC_BASE + (ADDR_W'(vec) << VEC_SHIFT);

    generate
        if (IDX_W >= ADDR_W) begin : g_idx_trunc
            assign idx_narrow = idx[ADDR_W-1:0];
        end else begin : g_idx_zext
            assign idx_narrow = {{(ADDR_W-IDX_W){1'b0}}, idx};
        end
    endgenerate

    always_comb begin
        unique case (ctrl.src)
            SRC_OADDR:  base = oaddr;
            SRC_PC:     base = pc;
            SRC_SP:     base = sp;
            SRC_VECTOR: base = vec_addr;
            default:    base = oaddr;
        endcase
    end

    assign idx_term = (ctrl.idx_en && !ctrl.idx_is_flags) ? idx_narrow : '0;
    assign inc_term = ADDR_W'(ctrl.inc);
    assign addr     = base + idx_term + inc_term;

endmodule

// File: rtl/aou_operand_reg.sv
module aou_operand_reg
    import aou_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  opnd_ctrl_t              ctrl,
    input  logic [BYTE_W-1:0]       rd,
    output logic [BYTE_W*BYTES-1:0] value
);
    localparam int CW = $clog2(BYTES + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTES);

    logic [BYTE_W-1:0] lane_q [BYTES];
    logic [CW-1:0]     fill_q;
    logic              full;
    logic              do_ext;

    assign full   = (fill_q == FULL);
    assign do_ext = ctrl.ext && !ctrl.load && !full;

    genvar i;
    generate
        for (i = 0; i < BYTES; i++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q[i] <= '0;
                end else if (ctrl.load) begin
                    lane_q[i] <= (i == 0) ? rd : '0;
                end else if (do_ext && (fill_q == CW'(i))) begin
                    lane_q[i] <= rd;
                end
            end
            assign value[i*BYTE_W +: BYTE_W] = lane_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (ctrl.load) begin
            fill_q <= CW'(1);
        end else if (do_ext) begin
            fill_q <= fill_q + CW'(1);
        end
    end

endmodule

// File: rtl/aou_oaddr_reg.sv
module aou_oaddr_reg
    import aou_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  oaddr_ctrl_t       ctrl,
    input  logic [BYTE_W-1:0] rd,
    input  logic [BYTE_W-1:0] opnd_lo,
    output logic [ADDR_W-1:0] value
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] q;
    oaddr_act_e        act;

    assign act = oaddr_decide(ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                OA_LOAD:     q <= {{HI_W{1'b0}}, rd};
                OA_EXTEND:   q <= {HI_W'(rd), q[BYTE_W-1:0]};
                OA_FROM_OPN: q <= {HI_W'(rd), opnd_lo};
                default:     q <= q;
            endcase
        end
    end

    assign value = q;

endmodule

// File: rtl/addr_operand_unit.sv
module addr_operand_unit
    import aou_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BYTE_W     = 8,
    parameter int OPND_BYTES = 4,
    parameter int IDX_W      = 32,
    parameter int VEC_W      = 4,
    localparam int OPND_W    = BYTE_W * OPND_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        src_sel,
    input  logic              addr_inc,
    input  logic              idx_en,
    input  logic              idx_is_flags,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [VEC_W-1:0]  vec_sel,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              opnd_load,
    input  logic              opnd_ext,
    input  logic              oaddr_load,
    input  logic              oaddr_ext,
    input  logic              oaddr_ext_opnd,
    input  logic              pc_load,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [OPND_W-1:0] operand,
    output logic [ADDR_W-1:0] pc_next
);
    addr_ctrl_t        a_ctrl;
    opnd_ctrl_t        o_ctrl;
    oaddr_ctrl_t       oa_ctrl;
    logic [ADDR_W-1:0] oaddr_q;

    assign a_ctrl  = '{src: addr_src_e'(src_sel), inc: addr_inc,
                       idx_en: idx_en, idx_is_flags: idx_is_flags};
    assign o_ctrl  = '{load: opnd_load, ext: opnd_ext};
    assign oa_ctrl = '{load: oaddr_load, ext: oaddr_ext, ext_opnd: oaddr_ext_opnd};

    aou_operand_reg #(.BYTE_W(BYTE_W), .BYTES(OPND_BYTES)) u_opnd (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (o_ctrl),
        .rd    (rd_data),
        .value (operand)
    );

    aou_oaddr_reg #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_oaddr (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (oa_ctrl),
        .rd      (rd_data),
        .opnd_lo (operand[BYTE_W-1:0]),
        .value   (oaddr_q)
    );

    aou_addr_path #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_path (
        .ctrl  (a_ctrl),
        .oaddr (oaddr_q),
        .pc    (pc_in),
        .sp    (sp_in),
        .vec   (vec_sel),
        .idx   (idx_val),
        .addr  (mem_addr)
    );

    assign pc_next = pc_load ? oaddr_q : pc_in;

endmodule

// File: rtl/addr_operand_unit_chk.sv
module addr_operand_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int OPND_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        src_sel,
    input logic              addr_inc,
    input logic              idx_en,
    input logic [ADDR_W-1:0] pc_in,
    input logic [BYTE_W-1:0] rd_data,
    input logic              opnd_load,
    input logic              opnd_ext,
    input logic              oaddr_load,
    input logic              oaddr_ext,
    input logic              oaddr_ext_opnd,
    input logic              pc_load,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [OPND_W-1:0] operand,
    input logic [ADDR_W-1:0] pc_next,
    input logic [ADDR_W-1:0] oaddr_q
);
    logic was_rst;
    always_ff @(posedge clk) was_rst <= rst;

    // R1: one cycle after reset both registers read zero
    always_ff @(negedge clk) begin
        if (was_rst) begin
            assert_reset_clear_R1: assert (operand == '0 && oaddr_q == '0);
        end
    end

    assert_opnd_load_R5: assert property (@(posedge clk) disable iff (rst)
        opnd_load |=> operand == OPND_W'($past(rd_data)));

    assert_opnd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!opnd_load && !opnd_ext) |=> $stable(operand));

    assert_oaddr_load_R8: assert property (@(posedge clk) disable iff (rst)
        oaddr_load |=> oaddr_q == ADDR_W'($past(rd_data)));

    assert_oaddr_from_opnd_R10: assert property (@(posedge clk) disable iff (rst)
        (oaddr_ext_opnd && !oaddr_load && !oaddr_ext) |=>
        oaddr_q == {$past(rd_data), $past(operand[BYTE_W-1:0])});

    assert_oaddr_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!oaddr_load && !oaddr_ext && !oaddr_ext_opnd) |=> $stable(oaddr_q));

    assert_pc_load_R11: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> pc_next == oaddr_q);

    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'd1 && addr_inc && !idx_en && pc_in == '1) |-> mem_addr == '0);

endmodule

bind addr_operand_unit addr_operand_unit_chk #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .OPND_W(OPND_W)
) u_chk (
    .clk(clk), .rst(rst), .src_sel(src_sel), .addr_inc(addr_inc), .idx_en(idx_en),
    .pc_in(pc_in), .rd_data(rd_data), .opnd_load(opnd_load), .opnd_ext(opnd_ext),
    .oaddr_load(oaddr_load), .oaddr_ext(oaddr_ext), .oaddr_ext_opnd(oaddr_ext_opnd),
    .pc_load(pc_load), .mem_addr(mem_addr), .operand(operand), .pc_next(pc_next),
    .oaddr_q(oaddr_q)
);

// File: tb/addr_operand_unit_bench.sv
module addr_operand_unit_bench;

    typedef struct packed {
        logic [1:0]  sel;
        logic        inc;
        logic        ien;
        logic        iflg;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [3:0]  vec;
        logic [31:0] idx;
        logic [15:0] exp;
    } avec_t;

    // operand-address register holds 0x1234 while this table runs
    localparam int NV = 13;
    localparam avec_t TAB [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h0, 32'h0, 16'h1234},
        '{2'd1, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h0000, 4'h0, 32'h0, 16'h8000},
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h01FF, 4'h0, 32'h0, 16'h01FF},
        '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h0, 32'h0, 16'hFFE0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'hF, 32'h0, 16'hFFFE},
        '{2'd1, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 4'h0, 32'h0, 16'h0000},
        '{2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h0, 32'h0, 16'h1235},
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'h0, 32'h10, 16'h1244},
        '{2'd0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000, 4'h0, 32'h10, 16'h1234},
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'hFFF0, 16'h0000, 4'h0, 32'h0001_0020, 16'h0011},
        '{2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0100, 4'h0, 32'h5, 16'h0106},
        '{2'd3, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h3, 32'h0, 16'hFFE7},
        '{2'd1, 1'b1, 1'b1, 1'b1, 16'h1000, 16'h0000, 4'h0, 32'hFFFF, 16'h1001}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  src_sel;
    logic        addr_inc, idx_en, idx_is_flags;
    logic [31:0] idx_val;
    logic [15:0] pc_in, sp_in;
    logic [3:0]  vec_sel;
    logic [7:0]  rd_data;
    logic        opnd_load, opnd_ext, oaddr_load, oaddr_ext, oaddr_ext_opnd, pc_load;
    logic [15:0] mem_addr;
    logic [31:0] operand;
    logic [15:0] pc_next;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    addr_operand_unit u_addr_operand_unit (
        .clk(clk), .rst(rst), .src_sel(src_sel), .addr_inc(addr_inc), .idx_en(idx_en),
        .idx_is_flags(idx_is_flags), .idx_val(idx_val), .pc_in(pc_in), .sp_in(sp_in),
        .vec_sel(vec_sel), .rd_data(rd_data), .opnd_load(opnd_load), .opnd_ext(opnd_ext),
        .oaddr_load(oaddr_load), .oaddr_ext(oaddr_ext), .oaddr_ext_opnd(oaddr_ext_opnd),
        .pc_load(pc_load), .mem_addr(mem_addr), .operand(operand), .pc_next(pc_next)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        src_sel = 2'd0; addr_inc = 0; idx_en = 0; idx_is_flags = 0; idx_val = '0;
        pc_in = '0; sp_in = '0; vec_sel = '0; rd_data = '0;
        opnd_load = 0; opnd_ext = 0; oaddr_load = 0; oaddr_ext = 0;
        oaddr_ext_opnd = 0; pc_load = 0;
    endtask

    // one rising edge, return at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // read operand-address register through mem_addr, source 0
    task automatic check_oaddr(string req, logic [15:0] exp);
        idle();
        #5;
        check(req, 32'(mem_addr), 32'(exp));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        step(); step();
        // R1: reset state
        check("R1 operand", operand, 32'h0);
        check_oaddr("R1 oaddr", 16'h0000);
        pc_load = 1; #2;
        check("R1 pc_next", 32'(pc_next), 32'h0);
        rst = 0;
        idle();

        // R8/R9: build 0x1234 in the address register
        rd_data = 8'h34; oaddr_load = 1; step();
        check_oaddr("R8 load", 16'h0034);
        rd_data = 8'h12; oaddr_ext = 1; step();
        check_oaddr("R9 extend", 16'h1234);

        // R2 R3 R4: address table
        for (int k = 0; k < NV; k++) begin
            idle();
            src_sel = TAB[k].sel; addr_inc = TAB[k].inc; idx_en = TAB[k].ien;
            idx_is_flags = TAB[k].iflg; pc_in = TAB[k].pc; sp_in = TAB[k].sp;
            vec_sel = TAB[k].vec; idx_val = TAB[k].idx;
            #5;
            check($sformatf("R2/R3/R4 vector %0d", k), 32'(mem_addr), 32'(TAB[k].exp));
            @(negedge clk);
        end
        idle();

        // R5/R6: operand assembly
        rd_data = 8'hAA; opnd_load = 1; step(); idle();
        check("R5 load", operand, 32'h0000_00AA);
        rd_data = 8'hBB; opnd_ext = 1; step(); idle();
        check("R6 second byte", operand, 32'h0000_BBAA);
        rd_data = 8'hCC; opnd_ext = 1; step();
        rd_data = 8'hDD; opnd_ext = 1; step(); idle();
        check("R6 four bytes", operand, 32'hDDCC_BBAA);
        rd_data = 8'hEE; opnd_ext = 1; step(); idle();
        check("R6 extend when full", operand, 32'hDDCC_BBAA);

        // R7: load wins over extend, fill restarts at one
        rd_data = 8'h11; opnd_load = 1; opnd_ext = 1; step(); idle();
        check("R7 load priority", operand, 32'h0000_0011);
        rd_data = 8'h22; opnd_ext = 1; step(); idle();
        check("R7 fill after load", operand, 32'h0000_2211);

        // R12: hold
        rd_data = 8'h5A; step(); step();
        check("R12 operand hold", operand, 32'h0000_2211);
        check_oaddr("R12 oaddr hold", 16'h1234);

        // R10: extend from operand, then priority
        rd_data = 8'h77; oaddr_ext_opnd = 1; step();
        check_oaddr("R10 from operand", 16'h7711);
        rd_data = 8'h05; oaddr_load = 1; oaddr_ext_opnd = 1; step();
        check_oaddr("R10 load beats from-operand", 16'h0005);
        rd_data = 8'h66; oaddr_ext = 1; oaddr_ext_opnd = 1; step();
        check_oaddr("R10 extend beats from-operand", 16'h6605);

        // R11: pc passthrough and load
        pc_in = 16'h4000; #2;
        check("R11 no load", 32'(pc_next), 32'h4000);
        pc_load = 1; #2;
        check("R11 load", 32'(pc_next), 32'h6605);
        idle();

        // R1: reset mid-run clears fill as well
        rst = 1; step(); rst = 0;
        check("R1 operand after rerun reset", operand, 32'h0);
        rd_data = 8'h99; opnd_ext = 1; step(); idle();
        check("R1 fill cleared", operand, 32'h0000_0099);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule